// File: doc/BRIEF.md
# Fine-Bin Code-Density Calibrator

This block calibrates the fine interpolator of a time-to-digital converter by statistics, then applies the calibration to live data. In calibration mode, hits that are uncorrelated with the converter clock arrive, and the block counts how many land in each raw fine code. Once a fixed, power-of-two number of hits has been collected, each bin's width is taken to be its share of the total times the clock period. The block then writes a lookup table in which each entry holds the time of that bin's centre, in picoseconds.

In run mode, every valid raw fine code is replaced by its table entry. The corrected time and its valid flag come out one cycle later. Software or a supervising controller can start a new calibration at any time, for example after a temperature change. A new start discards whatever collection or table build is in progress.

After reset, the table holds the centres of an ideal, evenly spaced set of bins, so corrected times are usable before the first calibration.

Top module: `fine_bin_calibrator`

## Requirements
- R1: After reset, `cal_done` and `time_vld` are 0 and table entry i equals ((2i+1)·PERIOD_PS) >> (CODE_W+1), the centre of an ideal evenly spaced bin.
- R2: A `cal_start` pulse while `cal_mode` is 1 clears every bin count and `cal_done` on the next clock edge and begins a new collection.
- R3: During collection, each cycle with `code_vld`=1 and `cal_mode`=1 adds one to the bin addressed by `code_in`. Hits presented while `cal_mode`=0 are neither counted toward any bin nor toward the total.
- R4: Collection ends on exactly the 2^HITS_LOG2-th counted hit. The table is then rebuilt one bin per cycle, and `cal_done` rises within CODE_W-derived 2^CODE_W+2 cycles of that hit. It stays high until the next accepted start.
- R5: After a calibration, table entry i equals ((2·S_i + c_i)·PERIOD_PS) >> (HITS_LOG2+1), where c_i is bin i's count and S_i is the sum of the counts of bins 0..i-1. This is the cumulative width of the earlier bins plus half of bin i's own width.
- R6: Bin counters saturate at 2^BIN_W−1 and do not wrap. Hits beyond saturation still count toward the collection total.
- R7: In run mode (`cal_mode`=0), a hit with `code_vld`=1 produces `time_vld`=1 one cycle later, with `time_out` equal to the table entry for that code.
- R8: A hit presented while `cal_mode`=1 never produces `time_vld`.
- R9: A start accepted during an unfinished collection discards all counts gathered so far. The result depends only on hits after the last start.
- R10: `cal_start` while `cal_mode`=0 has no effect: neither `cal_done` nor the table changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_mode | input | 1 | 1 routes hits to the histogram, 0 routes them to correction |
| cal_start | input | 1 | Start pulse for a calibration, honoured only in calibration mode |
| code_in | input | CODE_W | Raw fine code of a hit |
| code_vld | input | 1 | `code_in` carries a hit this cycle |
| cal_done | output | 1 | A calibration completed and the table is current |
| time_out | output | TIME_W | Corrected fine time in picoseconds |
| time_vld | output | 1 | `time_out` is valid |

## Verification
A wrong bin count or a broken cumulative sum shows up at the ports only through run-mode reads. Each is therefore followed by a read of every code, and one bad count shifts the entry of its own bin and of every later bin. A total counter that stops early or late shows up as `cal_done` rising too soon or never. This is checked by holding back the final hit and watching `cal_done` stay low. Stale counts from an aborted collection would offset all later entries on the first read after the rebuild.

// File: rtl/tdccal_pkg.sv
package tdccal_pkg;

   // Centre of bin idx when all 2^nbins_log2 bins are equally wide.
   function automatic longint unsigned ideal_center(input int unsigned idx,
                                                    input int unsigned nbins_log2,
                                                    input int unsigned period);
      longint unsigned num;
      num = (2 * longint'(idx) + 1) * longint'(period);
      return num >> (nbins_log2 + 1);
   endfunction

endpackage

// File: rtl/tdccal_hist.sv
module tdccal_hist #(
   parameter int CODE_W = 4,
   parameter int BIN_W  = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              inc,
   input  logic [CODE_W-1:0] inc_code,
   input  logic [CODE_W-1:0] rd_idx,
   output logic [BIN_W-1:0]  rd_cnt
);
   localparam int NBINS = 1 << CODE_W;
   localparam logic [BIN_W-1:0] CNT_MAX = '1;

   logic [BIN_W-1:0] cnt [NBINS];

   for (genvar i = 0; i < NBINS; i++) begin : g_bin
      logic [BIN_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cnt_q <= '0;
         else if (clr)
            cnt_q <= '0;
         else if (inc && (inc_code == CODE_W'(i)) && (cnt_q != CNT_MAX))
            cnt_q <= cnt_q + 1'b1;
      end
      assign cnt[i] = cnt_q;
   end

   assign rd_cnt = cnt[rd_idx];
endmodule

// File: rtl/tdccal_builder.sv
module tdccal_builder #(
   parameter int CODE_W    = 4,
   parameter int BIN_W     = 17,
   parameter int HITS_LOG2 = 16,
   parameter int PERIOD_PS = 8000,
   parameter int TIME_W    = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic              abort,
   output logic [CODE_W-1:0] rd_idx,
   input  logic [BIN_W-1:0]  rd_cnt,
   output logic              wr_en,
   output logic [CODE_W-1:0] wr_idx,
   output logic [TIME_W-1:0] wr_val,
   output logic              fin
);
   localparam int NBINS  = 1 << CODE_W;
   localparam int ACC_W  = BIN_W + CODE_W;
   localparam int NUM_W  = ACC_W + 1;
   localparam int PS_W   = $clog2(PERIOD_PS + 1);
   localparam int PROD_W = NUM_W + PS_W;
   localparam int SHIFT  = HITS_LOG2 + 1;

   logic              active_q;
   logic [CODE_W-1:0] idx_q;
   logic [ACC_W-1:0]  acc_q;
   logic [NUM_W-1:0]  num;
   logic [PROD_W-1:0] prod;

   // twice the earlier widths plus this bin's own, in hit units
   assign num  = {acc_q, 1'b0} + NUM_W'(rd_cnt);
   assign prod = PROD_W'(num) * PROD_W'(PERIOD_PS);

   assign rd_idx = idx_q;
   assign wr_en  = active_q;
   assign wr_idx = idx_q;
   assign wr_val = TIME_W'(prod >> SHIFT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         idx_q    <= '0;
         acc_q    <= '0;
         fin      <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (abort) begin
            active_q <= 1'b0;
         end else if (go) begin
            active_q <= 1'b1;
            idx_q    <= '0;
            acc_q    <= '0;
         end else if (active_q) begin
            acc_q <= acc_q + ACC_W'(rd_cnt);
            idx_q <= idx_q + 1'b1;
            if (idx_q == CODE_W'(NBINS - 1)) begin
               active_q <= 1'b0;
               fin      <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/tdccal_lut.sv
module tdccal_lut #(
   parameter int CODE_W    = 4,
   parameter int TIME_W    = 13,
   parameter int PERIOD_PS = 8000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CODE_W-1:0] wr_idx,
   input  logic [TIME_W-1:0] wr_val,
   input  logic              rd_en,
   input  logic [CODE_W-1:0] rd_code,
   output logic [TIME_W-1:0] rd_time,
   output logic              rd_vld
);
   localparam int NBINS = 1 << CODE_W;

   logic [TIME_W-1:0] tab [NBINS];

   for (genvar i = 0; i < NBINS; i++) begin : g_entry
      localparam logic [TIME_W-1:0] INIT =
         TIME_W'(tdccal_pkg::ideal_center(i, CODE_W, PERIOD_PS));
      logic [TIME_W-1:0] ent_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ent_q <= INIT;
         else if (wr_en && (wr_idx == CODE_W'(i)))
            ent_q <= wr_val;
      end
      assign tab[i] = ent_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_time <= '0;
         rd_vld  <= 1'b0;
      end else begin
         rd_vld <= rd_en;
         if (rd_en)
            rd_time <= tab[rd_code];
      end
   end
endmodule

// File: rtl/fine_bin_calibrator.sv
module fine_bin_calibrator #(
   parameter int CODE_W    = 4,
   parameter int HITS_LOG2 = 16,
   parameter int BIN_W     = HITS_LOG2 + 1,
   parameter int PERIOD_PS = 8000,
   parameter int TIME_W    = $clog2(PERIOD_PS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cal_mode,
   input  logic              cal_start,
   input  logic [CODE_W-1:0] code_in,
   input  logic              code_vld,
   output logic              cal_done,
   output logic [TIME_W-1:0] time_out,
   output logic              time_vld
);
   localparam int TOT_W = HITS_LOG2 + 1;
   localparam logic [TOT_W-1:0] LAST_HIT = TOT_W'((1 << HITS_LOG2) - 1);

   if (CODE_W < 1) begin : g_bad_code
      $error("CODE_W must be at least 1");
   end
   if (HITS_LOG2 < 1) begin : g_bad_hits
      $error("HITS_LOG2 must be at least 1");
   end
   if (BIN_W < 1 || BIN_W > HITS_LOG2 + 1) begin : g_bad_bin
      $error("BIN_W must lie in 1..HITS_LOG2+1");
   end
   if (PERIOD_PS < 2 || (1 << TIME_W) < PERIOD_PS) begin : g_bad_time
      $error("TIME_W too narrow for PERIOD_PS");
   end

   logic              start_acc;
   logic              hit_acc;
   logic              last_hit;
   logic              collecting;
   logic [TOT_W-1:0]  total_q;
   logic [CODE_W-1:0] b_rd_idx;
   logic [BIN_W-1:0]  b_rd_cnt;
   logic              b_wr_en;
   logic [CODE_W-1:0] b_wr_idx;
   logic [TIME_W-1:0] b_wr_val;
   logic              b_fin;

   assign start_acc = cal_start & cal_mode;
   assign hit_acc   = collecting & cal_mode & code_vld;
   assign last_hit  = hit_acc & (total_q == LAST_HIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         collecting <= 1'b0;
         total_q    <= '0;
         cal_done   <= 1'b0;
      end else begin
         if (start_acc) begin
            collecting <= 1'b1;
            total_q    <= '0;
            cal_done   <= 1'b0;
         end else begin
            if (hit_acc)
               total_q <= total_q + 1'b1;
            if (last_hit)
               collecting <= 1'b0;
            if (b_fin)
               cal_done <= 1'b1;
         end
      end
   end

   tdccal_hist #(
      .CODE_W (CODE_W),
      .BIN_W  (BIN_W)
   ) i_hist (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (start_acc),
      .inc      (hit_acc),
      .inc_code (code_in),
      .rd_idx   (b_rd_idx),
      .rd_cnt   (b_rd_cnt)
   );

   tdccal_builder #(
      .CODE_W    (CODE_W),
      .BIN_W     (BIN_W),
      .HITS_LOG2 (HITS_LOG2),
      .PERIOD_PS (PERIOD_PS),
      .TIME_W    (TIME_W)
   ) i_builder (
      .clk    (clk),
      .rst_n  (rst_n),
      .go     (last_hit),
      .abort  (start_acc),
      .rd_idx (b_rd_idx),
      .rd_cnt (b_rd_cnt),
      .wr_en  (b_wr_en),
      .wr_idx (b_wr_idx),
      .wr_val (b_wr_val),
      .fin    (b_fin)
   );

   tdccal_lut #(
      .CODE_W    (CODE_W),
      .TIME_W    (TIME_W),
      .PERIOD_PS (PERIOD_PS)
   ) i_lut (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (b_wr_en),
      .wr_idx  (b_wr_idx),
      .wr_val  (b_wr_val),
      .rd_en   (code_vld & ~cal_mode),
      .rd_code (code_in),
      .rd_time (time_out),
      .rd_vld  (time_vld)
   );
endmodule

// File: rtl/fine_bin_calibrator_chk.sv
module fine_bin_calibrator_chk #(
   parameter int HITS_LOG2 = 16,
   parameter int PERIOD_PS = 8000,
   parameter int TIME_W    = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cal_mode,
   input logic              cal_start,
   input logic              code_vld,
   input logic              collecting,
   input logic              cal_done,
   input logic              time_vld,
   input logic [TIME_W-1:0] time_out
);
   localparam int HW = HITS_LOG2 + 2;
   logic [HW-1:0] hits_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hits_q <= '0;
      else if (cal_start && cal_mode)
         hits_q <= '0;
      else if (collecting && cal_mode && code_vld)
         hits_q <= hits_q + 1'b1;
   end

   assert_vld_after_run_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      time_vld |-> $past(code_vld && !cal_mode));

   assert_quiet_in_cal_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (code_vld && cal_mode) |=> !time_vld);

   assert_start_clears_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_start && cal_mode) |=> !cal_done);

   assert_run_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_done && !(cal_start && cal_mode)) |=> cal_done);

   assert_exact_total_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cal_done) |-> (hits_q == HW'(1 << HITS_LOG2)));

   assert_time_in_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
      time_vld |-> (32'(time_out) < 32'(PERIOD_PS)));
endmodule

bind fine_bin_calibrator fine_bin_calibrator_chk #(
   .HITS_LOG2 (HITS_LOG2),
   .PERIOD_PS (PERIOD_PS),
   .TIME_W    (TIME_W)
) i_chk (.*);

// File: tb/test_fine_bin_calibrator.sv
module test_fine_bin_calibrator;
   localparam int CW     = 3;
   localparam int NB     = 1 << CW;
   localparam int HL     = 6;
   localparam int BW     = 6;
   localparam int PER    = 8000;
   localparam int TW     = $clog2(PER);
   localparam int SATMAX = (1 << BW) - 1;

   // hit distributions, each summing to 2^HL
   localparam int unsigned ROWS [4][NB] = '{
      '{8, 8, 8, 8, 8, 8, 8, 8},
      '{1, 3, 5, 7, 9, 11, 13, 15},
      '{20, 4, 4, 4, 4, 4, 4, 20},
      '{0, 16, 0, 16, 0, 16, 0, 16}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cal_mode = 1'b0;
   logic cal_start = 1'b0;
   logic [CW-1:0] code_in = '0;
   logic code_vld = 1'b0;
   logic cal_done;
   logic [TW-1:0] time_out;
   logic time_vld;

   int checks = 0;
   int errors = 0;
   int unsigned cur [NB];
   int unsigned prev [NB];

   always #4 clk = ~clk;

   fine_bin_calibrator #(
      .CODE_W (CW), .HITS_LOG2 (HL), .BIN_W (BW), .PERIOD_PS (PER)
   ) i_fine_bin_calibrator (
      .clk (clk), .rst_n (rst_n), .cal_mode (cal_mode), .cal_start (cal_start),
      .code_in (code_in), .code_vld (code_vld), .cal_done (cal_done),
      .time_out (time_out), .time_vld (time_vld)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int unsigned exp_entry(input int unsigned c [NB], input int i);
      int unsigned s = 0;
      int unsigned own;
      for (int j = 0; j < i; j++) s += (c[j] > SATMAX) ? SATMAX : c[j];
      own = (c[i] > SATMAX) ? SATMAX : c[i];
      return ((2 * s + own) * PER) >> (HL + 1);
   endfunction

   task automatic start_cal(input bit mode);
      @(negedge clk);
      cal_mode = mode; cal_start = 1'b1; code_vld = 1'b0;
      @(negedge clk);
      cal_start = 1'b0;
   endtask

   task automatic feed_hit(input int code, input string req);
      @(negedge clk);
      cal_mode = 1'b1; code_in = CW'(code); code_vld = 1'b1;
      @(negedge clk);
      code_vld = 1'b0;
      chk(time_vld == 1'b0, req, int'(time_vld), 0);
   endtask

   task automatic read_check(input int code, input int unsigned exp, input string req);
      @(negedge clk);
      cal_mode = 1'b0; code_in = CW'(code); code_vld = 1'b1;
      @(negedge clk);
      code_vld = 1'b0;
      chk(time_vld == 1'b1, req, int'(time_vld), 1);
      chk(int'(time_out) == int'(exp), req, int'(time_out), int'(exp));
   endtask

   task automatic wait_done(input string req);
      int n = 0;
      while (!cal_done && n < NB + 2) begin
         @(negedge clk);
         n++;
      end
      chk(cal_done == 1'b1, req, int'(cal_done), 1);
   endtask

   task automatic read_all(input int unsigned c [NB], input string req);
      for (int i = 0; i < NB; i++) read_check(i, exp_entry(c, i), req);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      chk(cal_done == 1'b0, "R1", int'(cal_done), 0);
      chk(time_vld == 1'b0, "R1", int'(time_vld), 0);
      rst_n = 1'b1;
      // R1: ideal table after reset, read through run mode (R7)
      for (int i = 0; i < NB; i++) read_check(i, ((2 * i + 1) * PER) >> (CW + 1), "R1");
      for (int i = 0; i < NB; i++) prev[i] = ((2 * i + 1) * PER) >> (CW + 1) << (HL - CW + 1) >> (HL - CW + 1);

      // table-driven calibrations
      for (int r = 0; r < 4; r++) begin
         for (int i = 0; i < NB; i++) cur[i] = ROWS[r][i];
         start_cal(1'b1);
         chk(cal_done == 1'b0, "R2", int'(cal_done), 0);
         for (int i = 0; i < NB; i++) begin
            for (int k = 0; k < int'(cur[i]); k++) feed_hit(i, "R8");
            // R3: run-mode hit mid-collection uses old table and is not counted
            if (r == 1 && i == 0) read_check(5, (r == 1) ? exp_entry(prev, 5) : 0, "R3");
         end
         wait_done("R4");
         read_all(cur, "R5");
         for (int i = 0; i < NB; i++) prev[i] = cur[i];
      end

      // R10: start in run mode is ignored
      start_cal(1'b0);
      @(negedge clk);
      chk(cal_done == 1'b1, "R10", int'(cal_done), 1);
      read_check(3, exp_entry(prev, 3), "R10");

      // R9: restart discards partial collection
      start_cal(1'b1);
      for (int k = 0; k < 30; k++) feed_hit(3, "R8");
      start_cal(1'b1);
      for (int i = 0; i < NB; i++) cur[i] = ROWS[0][i];
      for (int i = 0; i < NB; i++) for (int k = 0; k < 8; k++) feed_hit(i, "R8");
      wait_done("R9");
      read_all(cur, "R9");

      // R6 and R4: every hit on one code saturates its counter
      start_cal(1'b1);
      for (int k = 0; k < (1 << HL) - 1; k++) feed_hit(7, "R8");
      repeat (NB + 4) @(negedge clk);
      chk(cal_done == 1'b0, "R4", int'(cal_done), 0);
      feed_hit(7, "R8");
      wait_done("R4");
      for (int i = 0; i < NB; i++) cur[i] = 0;
      cur[7] = 1 << HL;
      read_check(0, 0, "R6");
      read_check(7, (SATMAX * PER) >> (HL + 1), "R6");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule